// File: doc/BRIEF.md
# Shared-Bus EPROM Bank Read Controller

This block runs read cycles on a bank of byte-wide EPROM devices that all hang on one data bus and one set of 12 address lines. A host hands it a read request as a single wide address over a valid/ready handshake. The bits above the low 12 pick the device. The controller pulls that device's chip-select low and keeps every other device's chip-select high, so the unselected parts sit in standby. The low 12 bits go to the shared address lines. One output-enable line is wired to every device and acts as the bank's read strobe.

Each access time is a parameter in nanoseconds. The block turns each one into a whole number of clock cycles, rounding up. The controller keeps the chip-select low for the longer of the address-to-data and select-to-data budgets. It lowers the shared output-enable only as late as the output-enable-to-data budget allows. It captures the byte on the edge where the last budget runs out. On that same edge it raises chip-select and output-enable, then returns the byte with a one-cycle done pulse.

After a release, the old device may keep driving the bus until its float time has passed. A following request to a different device therefore waits out whatever is left of that float window before the new device is selected. A request to the same device starts at once.

Top module: `eprom_bank_rd`

## Requirements
- R1: During and after reset, with no request yet, req_ready is 1, every mem_ce_n bit is 1, mem_oe_n is 1 and rsp_done is 0.
- R2: At most one mem_ce_n bit is ever 0. When one is low, it is bit number req_addr[ADDR_W-1:12] of the request in progress.
- R3: While any chip-select is low, mem_addr equals req_addr[11:0] of the request in progress and does not change.
- R4: Each read keeps the selected chip-select low for exactly N_ACC = max(ceil(T_ADDR_NS/CLK_NS), ceil(T_CE_NS/CLK_NS)) cycles. rsp_data then holds the byte the device presented after all three access budgets had elapsed.
- R5: mem_oe_n goes low only while a chip-select is low. It stays low for exactly N_OE = ceil(T_OE_NS/CLK_NS) cycles before the sample edge (or for the whole select time if N_OE ≥ N_ACC).
- R6: On the sample edge all chip-selects and mem_oe_n return to 1. rsp_done is high for exactly one cycle, starting with that edge, and rsp_data is valid during it.
- R7: A different device's chip-select falls no sooner than N_FLT = ceil(T_FLOAT_NS/CLK_NS) cycles after the previous release. The result is a delay of max(0, N_FLT − k) cycles when the request is accepted k cycles after that release.
- R8: A request to the device that was read last starts at once. Its latency from the accepting edge to the done edge is N_ACC.
- R9: req_ready is 1 only while idle. A request is taken on the first edge where req_valid and req_ready are both 1, and req_ready is 0 in the cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Controller can accept a request |
| req_addr | input | ADDR_W | Device number in the top bits, word address in bits 11:0 |
| rsp_done | output | 1 | One-cycle pulse: rsp_data holds the result |
| rsp_data | output | DATA_W | Captured byte |
| mem_addr | output | LOW_AW | Shared address lines |
| mem_ce_n | output | NUM_DEV | One active-low chip-select per device |
| mem_oe_n | output | 1 | Shared active-low output enable |
| mem_dq_in | input | DATA_W | Shared data bus as seen by the controller |

## Verification
The bench models four devices. Each one returns a computed byte only once its address, select and output-enable ages have reached their own limits. It also keeps driving for the float time after it is released, and any overlap between devices is counted as contention. Budgets are chosen so that rounding matters and the select budget exceeds the address budget, which separates the max(), ceil and late output-enable paths. The sweep covers every device with all-zero, all-one and walking-one addresses, back-to-back on one device (no gap). Alternating devices are issued at once (full float gap) and after idle delays on both sides of the float limit (partial and zero gap), so that the gap arithmetic is checked at its edges.

// File: rtl/eprom_rd_pkg.sv
package eprom_rd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_GAP    = 2'd1,
        ST_ACCESS = 2'd2
    } rd_state_e;

    // nanoseconds to whole clock cycles, rounded up
    function automatic int unsigned cyc_of(input int unsigned ns, input int unsigned clk_ns);
        return (ns + clk_ns - 1) / clk_ns;
    endfunction

endpackage

// File: rtl/eprom_ce_decode.sv
module eprom_ce_decode #(
    parameter int NUM_DEV = 4,
    parameter int SEL_W   = 2
) (
    input  logic               en,
    input  logic [SEL_W-1:0]   sel,
    output logic [NUM_DEV-1:0] ce_n
);
    for (genvar g = 0; g < NUM_DEV; g++) begin : g_sel
        assign ce_n[g] = ~(en && (sel == SEL_W'(g)));
    end
endmodule

// File: rtl/eprom_gap_timer.sv
module eprom_gap_timer #(
    parameter int N_FLT = 15,
    localparam int W = $clog2(N_FLT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic clear
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = W'(N_FLT - 1);
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign clear = (cnt_q == '0);
endmodule

// File: rtl/eprom_bank_rd.sv
module eprom_bank_rd
    import eprom_rd_pkg::*;
#(
    parameter int NUM_DEV    = 4,
    parameter int LOW_AW     = 12,
    parameter int DATA_W     = 8,
    parameter int CLK_NS     = 4,
    parameter int T_ADDR_NS  = 200,
    parameter int T_CE_NS    = 200,
    parameter int T_OE_NS    = 100,
    parameter int T_FLOAT_NS = 60,
    localparam int SEL_W  = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1,
    localparam int ADDR_W = LOW_AW + SEL_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [ADDR_W-1:0]  req_addr,
    output logic               rsp_done,
    output logic [DATA_W-1:0]  rsp_data,
    output logic [LOW_AW-1:0]  mem_addr,
    output logic [NUM_DEV-1:0] mem_ce_n,
    output logic               mem_oe_n,
    input  logic [DATA_W-1:0]  mem_dq_in
);
    localparam int unsigned N_ADDR  = cyc_of(T_ADDR_NS, CLK_NS);
    localparam int unsigned N_CE    = cyc_of(T_CE_NS, CLK_NS);
    localparam int unsigned N_OE    = cyc_of(T_OE_NS, CLK_NS);
    localparam int unsigned N_ACC0  = (N_ADDR > N_CE) ? N_ADDR : N_CE;
    localparam int unsigned N_ACC   = (N_ACC0 < 1) ? 1 : N_ACC0;
    localparam int unsigned N_FLT0  = cyc_of(T_FLOAT_NS, CLK_NS);
    localparam int unsigned N_FLT   = (N_FLT0 < 1) ? 1 : N_FLT0;
    localparam int unsigned OE_LEAD = (N_ACC > N_OE) ? N_ACC - N_OE : 0;
    localparam int CNT_W = $clog2(N_ACC + 1);
    localparam logic [CNT_W-1:0] LAST_C = CNT_W'(N_ACC - 1);
    localparam logic [CNT_W-1:0] LEAD_C = CNT_W'(OE_LEAD);

    typedef struct packed {
        rd_state_e          st;
        logic [CNT_W-1:0]   cnt;
        logic [SEL_W-1:0]   dev;
        logic [SEL_W-1:0]   last_dev;
        logic [LOW_AW-1:0]  addr;
        logic               oe_n;
        logic               done;
        logic [DATA_W-1:0]  data;
    } regs_t;

    regs_t r_d, r_q;
    logic [NUM_DEV-1:0] ce_n_d, ce_n_q;
    logic               flt_load, flt_clear;
    logic [SEL_W-1:0]   req_sel;

    assign req_sel = req_addr[ADDR_W-1:LOW_AW];

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        flt_load = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.dev  = req_sel;
                    r_d.addr = req_addr[LOW_AW-1:0];
                    if (!flt_clear && (req_sel != r_q.last_dev)) begin
                        r_d.st = ST_GAP;
                    end else begin
                        r_d.st   = ST_ACCESS;
                        r_d.cnt  = '0;
                        r_d.oe_n = (OE_LEAD != 0);
                    end
                end
            end
            ST_GAP: begin
                if (flt_clear) begin
                    r_d.st   = ST_ACCESS;
                    r_d.cnt  = '0;
                    r_d.oe_n = (OE_LEAD != 0);
                end
            end
            ST_ACCESS: begin
                if (r_q.cnt == LAST_C) begin
                    r_d.data     = mem_dq_in;
                    r_d.done     = 1'b1;
                    r_d.oe_n     = 1'b1;
                    r_d.st       = ST_IDLE;
                    r_d.last_dev = r_q.dev;
                    flt_load     = 1'b1;
                end else begin
                    r_d.cnt  = r_q.cnt + 1'b1;
                    r_d.oe_n = (r_d.cnt < LEAD_C);
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '{st: ST_IDLE, oe_n: 1'b1, default: '0};
            ce_n_q   <= '1;
        end else begin
            r_q      <= r_d;
            ce_n_q   <= ce_n_d;
        end
    end

    eprom_ce_decode #(.NUM_DEV(NUM_DEV), .SEL_W(SEL_W)) u_dec (
        .en   (r_d.st == ST_ACCESS),
        .sel  (r_d.dev),
        .ce_n (ce_n_d)
    );

    eprom_gap_timer #(.N_FLT(N_FLT)) u_gap (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (flt_load),
        .clear (flt_clear)
    );

    assign req_ready = (r_q.st == ST_IDLE);
    assign rsp_done  = r_q.done;
    assign rsp_data  = r_q.data;
    assign mem_addr  = r_q.addr;
    assign mem_oe_n  = r_q.oe_n;
    assign mem_ce_n  = ce_n_q;

    assert_one_select_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~mem_ce_n) <= 1);

    assert_addr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(&mem_ce_n) |=> (&mem_ce_n) || $stable(mem_addr));

    assert_oe_inside_ce_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> !(&mem_ce_n));

    assert_release_on_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> (&mem_ce_n) && mem_oe_n);

    assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    assert_busy_not_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(&mem_ce_n) |-> !req_ready);

endmodule

// File: tb/eprom_bank_rd_tb.sv
`timescale 1ns/1ps
module eprom_bank_rd_tb;
    localparam int NDEV = 4;
    localparam int LAW  = 12;
    localparam int AW   = LAW + 2;
    localparam int CLKP = 4;
    localparam int TA = 198, TC = 201, TO = 99, TF = 61;

    function automatic int ceil_cyc(input int ns);
        int c;
        c = ns / CLKP;
        if (c * CLKP < ns) c = c + 1;
        return c;
    endfunction

    localparam int E_ADDR = ceil_cyc(TA);
    localparam int E_CE   = ceil_cyc(TC);
    localparam int E_OE   = ceil_cyc(TO);
    localparam int E_ACC  = (E_ADDR > E_CE) ? E_ADDR : E_CE;
    localparam int E_FLT  = ceil_cyc(TF);

    logic clk = 0, rst_n = 0;
    logic req_valid = 0;
    logic [AW-1:0] req_addr = '0;
    logic req_ready, rsp_done, mem_oe_n;
    logic [7:0] rsp_data;
    logic [7:0] mem_dq_in = 8'hFF;
    logic [LAW-1:0] mem_addr;
    logic [NDEV-1:0] mem_ce_n;

    always #2 clk = ~clk;

    eprom_bank_rd #(.NUM_DEV(NDEV), .LOW_AW(LAW), .DATA_W(8), .CLK_NS(CLKP),
        .T_ADDR_NS(TA), .T_CE_NS(TC), .T_OE_NS(TO), .T_FLOAT_NS(TF)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .rsp_done(rsp_done), .rsp_data(rsp_data),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
        .mem_dq_in(mem_dq_in));

    int total = 0, bad = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] rom_val(input int dev, input int a);
        return 8'((a * 7) ^ (a >> 4) ^ (dev * 91) ^ 8'h3C);
    endfunction

    // device models, evaluated between edges
    int tce[NDEV], toe[NDEV], off_age[NDEV];
    int taddr = 0;
    logic [LAW-1:0] prev_addr = '0;
    int cur_dev = 0, cur_low = 0;
    int last_tce = 0, last_toe = 0;
    int v_sel = 0, v_addr = 0, v_bus = 0;

    initial for (int d = 0; d < NDEV; d++) begin
        tce[d] = 0; toe[d] = 0; off_age[d] = 1000;
    end

    always @(negedge clk) begin
        int nlow, ndrv, s;
        nlow = 0; ndrv = 0; s = -1;
        if (mem_addr != prev_addr) taddr = 1;
        else if (taddr < 100000) taddr = taddr + 1;
        prev_addr = mem_addr;
        for (int d = 0; d < NDEV; d++) begin
            bit en, on;
            en = !mem_ce_n[d];
            on = en && !mem_oe_n;
            tce[d] = en ? tce[d] + 1 : 0;
            toe[d] = on ? toe[d] + 1 : 0;
            if (on) off_age[d] = 0;
            else if (off_age[d] < 1000) off_age[d] = off_age[d] + 1;
            if (en) begin nlow++; s = d; end
            if (on || (off_age[d] >= 1 && off_age[d] <= E_FLT)) ndrv++;
        end
        if (rst_n) begin
            if (nlow > 1 || (nlow == 1 && s != cur_dev)) v_sel++;
            if (nlow >= 1 && int'(mem_addr) != cur_low) v_addr++;
            if (ndrv > 1) v_bus++;
        end
        if (s >= 0) begin
            last_tce = tce[s]; last_toe = toe[s];
            if (!mem_oe_n && tce[s] >= E_CE && taddr >= E_ADDR && toe[s] >= E_OE)
                mem_dq_in = rom_val(s, int'(mem_addr));
            else
                mem_dq_in = ~rom_val(s, int'(mem_addr));
        end else begin
            mem_dq_in = 8'hFF;
        end
    end

    bit have_prev = 0;
    int last_dev = 0, last_rel = 0;

    task automatic do_read(input int dev, input int a, input int idle);
        int acc, lat, gap, k, w;
        repeat (idle) @(negedge clk);
        @(negedge clk);
        cur_dev = dev; cur_low = a;
        req_addr = AW'((dev << LAW) | a);
        req_valid = 1;
        while (!req_ready) @(negedge clk);
        acc = cyc + 1;
        @(negedge clk);
        req_valid = 0;
        check(req_ready == 0, "R9 ready low after accept", int'(req_ready), 0);
        w = 0;
        while (!rsp_done && w < 1000) begin @(negedge clk); w++; end
        lat = cyc - acc;
        gap = 0;
        if (have_prev && dev != last_dev) begin
            k = acc - last_rel;
            gap = (E_FLT > k) ? E_FLT - k : 0;
        end
        if (have_prev && dev == last_dev)
            check(lat == E_ACC, "R8 same-device latency", lat, E_ACC);
        else
            check(lat == E_ACC + gap, "R7 float gap latency", lat, E_ACC + gap);
        check(rsp_data == rom_val(dev, a), "R4 data", int'(rsp_data), int'(rom_val(dev, a)));
        check(last_tce == E_ACC, "R4 select length", last_tce, E_ACC);
        check(last_toe == E_OE, "R5 output-enable length", last_toe, E_OE);
        check((&mem_ce_n) && mem_oe_n, "R6 release at sample", int'({mem_ce_n, mem_oe_n}), 31);
        have_prev = 1; last_dev = dev; last_rel = cyc;
        @(negedge clk);
        check(rsp_done == 0, "R6 done single cycle", int'(rsp_done), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(req_ready == 1, "R1 ready in reset", int'(req_ready), 1);
        check(mem_ce_n == '1, "R1 selects high", int'(mem_ce_n), 15);
        rst_n = 1;
        repeat (2) @(negedge clk);
        check(mem_oe_n == 1, "R1 oe high", int'(mem_oe_n), 1);
        check(rsp_done == 0, "R1 done low", int'(rsp_done), 0);
        check(req_ready == 1, "R1 ready idle", int'(req_ready), 1);

        for (int d = 0; d < NDEV; d++) begin
            do_read(d, 0, 0);
            do_read(d, 12'hFFF, 0);
            for (int b = 0; b < LAW; b++) do_read(d, 1 << b, 0);
        end
        for (int i = 0; i < 16; i++) do_read(i % NDEV, (i * 273) & 12'hFFF, 0);
        begin
            int holds[6] = '{0, 3, 13, 14, 15, 30};
            foreach (holds[j]) do_read(j % 2 == 0 ? 1 : 2, 100 + j, holds[j]);
        end
        do_read(3, 12'hABC, 2);
        do_read(3, 12'h123, 5);

        check(v_sel == 0, "R2 one correct select", v_sel, 0);
        check(v_addr == 0, "R3 address while selected", v_addr, 0);
        check(v_bus == 0, "R7 no bus contention", v_bus, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        check(0, "watchdog", cyc, 200000);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule